// File: doc/BRIEF.md
# Four-register byte execution core

This block is an 8-bit execution engine that accepts one instruction byte per clock on a valid/ready input. It does not fetch: whatever drives the instruction stream chooses the next byte. The core holds four 8-bit working registers and drives a byte-wide memory port. That port has an 8-bit address, 8-bit read data, 8-bit write data and one write-strobe line. Every register is visible on its own output port for observation.

Each cycle, every result the core can produce is formed side by side: nibble loads, copy, memory load, complement, sum, product, AND and OR. The decoded instruction then picks one of them, and it alone may update a register or strobe the memory port.

Memory reads complete within the cycle. The read byte is written into the register on the same rising edge that accepts the instruction.

Back-pressure rules:
- `instr_ready` is low only while reset is asserted. Outside reset the core takes one instruction per cycle and never stalls.
- An instruction executes only in a cycle where `instr_valid` and `instr_ready` are both high.
- When `instr_valid` is low, the core holds every register and keeps the write strobe low.

Top module: `byte_exec_core`

## Requirements
- R1: Four 8-bit registers are selected by 2-bit fields with 00=A, 01=B, 10=C and 11=D, and are shown on reg_a..reg_d. A synchronous active-high reset clears all four to zero and holds mem_we and instr_ready low.
- R2: Byte 00RRVVVV (R in bits 5:4, V in bits 3:0) loads V into bits 7:4 of register R and keeps bits 3:0.
- R3: Byte 01RRVVVV loads V into bits 3:0 of register R and keeps bits 7:4.
- R4: Byte 1000SSDD copies register S (bits 3:2) into register D (bits 1:0), leaving S unchanged unless S equals D.
- R5: Byte 100100RR drives mem_addr with register R in the same cycle and stores mem_rdata into R at that clock edge. mem_we stays low.
- R6: Bytes 100110RR and 100111RR both replace register R with its bitwise complement.
- R7: Byte 1010SSDD stores the low 8 bits of S+D into D, and byte 1011SSDD stores the low 8 bits of S×D into D. No carry is kept.
- R8: Byte 1100SSDD stores S AND D into D, and byte 1101SSDD stores S OR D into D.
- R9: Byte 1111SSDD raises mem_we for that cycle with mem_addr equal to register D and mem_wdata equal to register S. No register changes.
- R10: Bytes 100101xx and 1110xxxx change no register and never raise mem_we.
- R11: In any cycle without an accepted instruction, mem_we is low and no register changes. Outside any read or write cycle, mem_addr and mem_wdata are zero, and mem_wdata is zero during a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction byte present |
| instr_ready | output | 1 | Core accepts an instruction (low only in reset) |
| instr | input | 8 | Instruction byte |
| mem_addr | output | 8 | Memory address for load or store |
| mem_rdata | input | 8 | Byte returned by memory in the same cycle |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Store strobe, high for one accepted store |
| reg_a | output | 8 | Register A contents |
| reg_b | output | 8 | Register B contents |
| reg_c | output | 8 | Register C contents |
| reg_d | output | 8 | Register D contents |

## Verification
Nibble loads are applied to every register with distinct values. This separates a wrong register-select decode from a wrong half being kept. The sum and product use operands that overflow 8 bits, so truncation is distinguished from a widened or saturated result. Both complement codes, the unused codes and idle cycles carrying a store byte show that only an accepted, assigned code writes anything. A long pseudo-random byte stream, with memory data that changes every cycle, then catches operand-field swaps and address/data swaps on the store path.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int INSTR_W   = 8;
  localparam int NUM_REGS  = 4;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int IMM_W     = 4;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SETHI = 4'd1,
    OP_SETLO = 4'd2,
    OP_MOV   = 4'd3,
    OP_LOAD  = 4'd4,
    OP_CPL   = 4'd5,
    OP_ADD   = 4'd6,
    OP_MUL   = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_STORE = 4'd10
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] dst;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic               accept,
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.op  = OP_NOP;
    dec.src = instr[3:2];
    dec.dst = instr[1:0];
    dec.imm = instr[3:0];
    if (accept) begin
      casez (instr)
        8'b00??????: begin
          dec.op  = OP_SETHI;
          dec.src = instr[5:4];
          dec.dst = instr[5:4];
        end
        8'b01??????: begin
          dec.op  = OP_SETLO;
          dec.src = instr[5:4];
          dec.dst = instr[5:4];
        end
        8'b1000????: dec.op = OP_MOV;
        8'b100100??: dec.op = OP_LOAD;
        8'b10011???: dec.op = OP_CPL;
        8'b1010????: dec.op = OP_ADD;
        8'b1011????: dec.op = OP_MUL;
        8'b1100????: dec.op = OP_AND;
        8'b1101????: dec.op = OP_OR;
        8'b1111????: dec.op = OP_STORE;
        default:     dec.op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result,
  output logic              reg_we
);
  localparam int HALF = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] r_hi, r_lo, r_sum, r_prod, r_and, r_or, r_cpl;
  logic [PROD_W-1:0] prod_full;
  logic [HALF-1:0]   imm_half;

  assign imm_half  = HALF'(imm);
  // Every candidate result is formed in parallel each cycle.
  assign r_hi      = {imm_half, opb[HALF-1:0]};
  assign r_lo      = {opb[DATA_W-1:HALF], imm_half};
  assign r_sum     = opa + opb;
  assign prod_full = PROD_W'(opa) * PROD_W'(opb);
  assign r_prod    = prod_full[DATA_W-1:0];
  assign r_and     = opa & opb;
  assign r_or      = opa | opb;
  assign r_cpl     = ~opb;

  always_comb begin
    result = opb;
    reg_we = 1'b1;
    case (op)
      OP_SETHI: result = r_hi;
      OP_SETLO: result = r_lo;
      OP_MOV:   result = opa;
      OP_LOAD:  result = rdata;
      OP_CPL:   result = r_cpl;
      OP_ADD:   result = r_sum;
      OP_MUL:   result = r_prod;
      OP_AND:   result = r_and;
      OP_OR:    result = r_or;
      default:  reg_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [SEL_W-1:0]           wsel,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [SEL_W-1:0]           sel_a,
  input  logic [SEL_W-1:0]           sel_b,
  output logic [DATA_W-1:0]          rd_a,
  output logic [DATA_W-1:0]          rd_b,
  output logic [NUM_REGS*DATA_W-1:0] all_regs
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && wsel == SEL_W'(g)) regs[g] <= wdata;
    end
    assign all_regs[g*DATA_W +: DATA_W] = regs[g];
  end

  assign rd_a = regs[sel_a];
  assign rd_b = regs[sel_b];
endmodule

// File: rtl/byte_exec_core.sv
module byte_exec_core
  import core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr,
  output logic [DATA_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_we,
  output logic [DATA_W-1:0]  reg_a,
  output logic [DATA_W-1:0]  reg_b,
  output logic [DATA_W-1:0]  reg_c,
  output logic [DATA_W-1:0]  reg_d
);
  logic                       accept;
  dec_t                       dec;
  logic [DATA_W-1:0]          opa, opb, result;
  logic                       reg_we;
  logic [NUM_REGS*DATA_W-1:0] all_regs;
  logic                       is_load, is_store;

  assign instr_ready = ~rst;
  assign accept      = instr_valid & instr_ready;

  core_decode u_decode (
    .accept (accept),
    .instr  (instr),
    .dec    (dec)
  );

  core_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .wsel     (dec.dst),
    .wdata    (result),
    .sel_a    (dec.src),
    .sel_b    (dec.dst),
    .rd_a     (opa),
    .rd_b     (opb),
    .all_regs (all_regs)
  );

  core_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (dec.op),
    .opa    (opa),
    .opb    (opb),
    .imm    (dec.imm),
    .rdata  (mem_rdata),
    .result (result),
    .reg_we (reg_we)
  );

  // Memory port: the address comes from the low register field for both load and store.
  assign is_load   = (dec.op == OP_LOAD);
  assign is_store  = (dec.op == OP_STORE);
  assign mem_addr  = (is_load || is_store) ? opb : '0;
  assign mem_wdata = is_store ? opa : '0;
  assign mem_we    = is_store;

  assign reg_a = all_regs[0*DATA_W +: DATA_W];
  assign reg_b = all_regs[1*DATA_W +: DATA_W];
  assign reg_c = all_regs[2*DATA_W +: DATA_W];
  assign reg_d = all_regs[3*DATA_W +: DATA_W];
endmodule

// File: rtl/core_checks.sv
module core_checks (
  input logic       clk,
  input logic       rst,
  input logic       instr_valid,
  input logic       instr_ready,
  input logic [7:0] instr,
  input logic [7:0] mem_addr,
  input logic [7:0] mem_rdata,
  input logic [7:0] mem_wdata,
  input logic       mem_we,
  input logic [7:0] reg_a,
  input logic [7:0] reg_b,
  input logic [7:0] reg_c,
  input logic [7:0] reg_d
);
  logic [7:0]  rf [4];
  logic [31:0] snap;
  logic        acc;
  logic        rst_q = 1'b0;

  assign rf[0] = reg_a;
  assign rf[1] = reg_b;
  assign rf[2] = reg_c;
  assign rf[3] = reg_d;
  assign snap  = {reg_d, reg_c, reg_b, reg_a};
  assign acc   = instr_valid && instr_ready;

  always_ff @(posedge clk) rst_q <= rst;

  // R1: after a reset edge the registers are clear and the port is quiet
  always @(negedge clk) begin
    if (rst_q && rst)
      p_reset_clear_r1: assert (snap == 32'd0 && !mem_we && !instr_ready);
  end

  p_sethi_r2: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:6] == 2'b00 |=>
      rf[$past(instr[5:4])] == {$past(instr[3:0]), $past(rf[instr[5:4]][3:0])});

  p_setlo_r3: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:6] == 2'b01 |=>
      rf[$past(instr[5:4])] == {$past(rf[instr[5:4]][7:4]), $past(instr[3:0])});

  p_move_r4: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:4] == 4'b1000 |=>
      rf[$past(instr[1:0])] == $past(rf[instr[3:2]]));

  p_load_addr_r5: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:2] == 6'b100100 |-> mem_addr == rf[instr[1:0]] && !mem_we);

  p_load_data_r5: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:2] == 6'b100100 |=> rf[$past(instr[1:0])] == $past(mem_rdata));

  p_cpl_r6: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:3] == 5'b10011 |=>
      rf[$past(instr[1:0])] == ~$past(rf[instr[1:0]]));

  p_add_r7: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:4] == 4'b1010 |=>
      rf[$past(instr[1:0])] == 8'($past(rf[instr[3:2]]) + $past(rf[instr[1:0]])));

  p_or_r8: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:4] == 4'b1101 |=>
      rf[$past(instr[1:0])] == ($past(rf[instr[3:2]]) | $past(rf[instr[1:0]])));

  p_store_port_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> acc && instr[7:4] == 4'hF &&
      mem_addr == rf[instr[1:0]] && mem_wdata == rf[instr[3:2]]);

  p_store_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    acc && instr[7:4] == 4'hF |=> $stable(snap));

  p_unused_r10: assert property (@(posedge clk) disable iff (rst)
    acc && (instr[7:2] == 6'b100101 || instr[7:4] == 4'hE) |=> $stable(snap));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(snap));

  p_idle_port_r11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !mem_we && mem_addr == 8'd0 && mem_wdata == 8'd0);
endmodule

bind byte_exec_core core_checks u_checks (.*);

// File: tb/test_byte_exec_core.sv
`timescale 1ns/1ps
module test_byte_exec_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic       instr_ready;
  logic [7:0] instr = 8'h00;
  logic [7:0] mem_addr, mem_wdata, mem_rdata = 8'h00;
  logic       mem_we;
  logic [7:0] reg_a, reg_b, reg_c, reg_d;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  byte_exec_core i_byte_exec_core (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [7:0]  wdata;
    logic [31:0] regs;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [7:0]  m [4];

  function automatic logic [31:0] model_pack();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  // Driver: applies one byte at the falling edge, updates the model, queues the expectation.
  task automatic exec(input logic [7:0] ins, input logic [7:0] rd, input logic v);
    exp_t  e;
    string t;
    logic [1:0] hsel, s, d;
    @(negedge clk);
    instr = ins; mem_rdata = rd; instr_valid = v;
    hsel = ins[5:4]; s = ins[3:2]; d = ins[1:0];
    e.we = 1'b0; e.addr = 8'h00; e.wdata = 8'h00;
    t = "R11 idle";
    if (v) begin
      casez (ins)
        8'b00??????: begin m[hsel] = {ins[3:0], m[hsel][3:0]}; t = "R2 high nibble"; end
        8'b01??????: begin m[hsel] = {m[hsel][7:4], ins[3:0]}; t = "R3 low nibble"; end
        8'b1000????: begin m[d] = m[s]; t = "R4 move"; end
        8'b100100??: begin e.addr = m[d]; m[d] = rd; t = "R5 load"; end
        8'b10011???: begin m[d] = ~m[d]; t = "R6 complement"; end
        8'b1010????: begin m[d] = m[s] + m[d]; t = "R7 add"; end
        8'b1011????: begin m[d] = 8'((16'(m[s]) * 16'(m[d])) & 16'h00FF); t = "R7 multiply"; end
        8'b1100????: begin m[d] = m[s] & m[d]; t = "R8 and"; end
        8'b1101????: begin m[d] = m[s] | m[d]; t = "R8 or"; end
        8'b1111????: begin e.we = 1'b1; e.addr = m[d]; e.wdata = m[s]; t = "R9 store"; end
        default:     t = "R10 unused code";
      endcase
    end
    e.regs = model_pack();
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: port values mid-cycle, register values just after the edge.
  initial begin
    logic        s_we, s_rdy;
    logic [7:0]  s_addr, s_wdata;
    logic [31:0] s_regs;
    exp_t        e;
    string       t;
    forever begin
      @(negedge clk); #1;
      s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata; s_rdy = instr_ready;
      @(posedge clk); #1;
      s_regs = {reg_d, reg_c, reg_b, reg_a};
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (s_we !== e.we || s_addr !== e.addr || s_wdata !== e.wdata ||
            s_regs !== e.regs || s_rdy !== 1'b1) begin
          failures++;
          $display("FAIL %s: got we=%b addr=%h wdata=%h regs=%h rdy=%b, expected we=%b addr=%h wdata=%h regs=%h rdy=1",
                   t, s_we, s_addr, s_wdata, s_regs, s_rdy, e.we, e.addr, e.wdata, e.regs);
        end
      end
    end
  end

  task automatic check_reset_state(input string t);
    checks++;
    if ({reg_d, reg_c, reg_b, reg_a} !== 32'd0 || mem_we !== 1'b0 || instr_ready !== 1'b0) begin
      failures++;
      $display("FAIL %s: got regs=%h we=%b rdy=%b, expected regs=0 we=0 rdy=0",
               t, {reg_d, reg_c, reg_b, reg_a}, mem_we, instr_ready);
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1 check_reset_state("R1 reset state");
    @(negedge clk); rst = 1'b0;

    // R2/R3 on every register select value
    for (int r = 0; r < 4; r++) exec({2'b00, 2'(r), 4'(r + 1)}, 8'h00, 1'b1);
    for (int r = 0; r < 4; r++) exec({2'b01, 2'(r), 4'(9 + r)}, 8'h00, 1'b1);
    exec({2'b00, 2'd2, 4'hF}, 8'h00, 1'b1);       // R2 keeps the low half
    exec({2'b01, 2'd1, 4'h0}, 8'h00, 1'b1);       // R3 keeps the high half
    exec({4'b1000, 2'd0, 2'd3}, 8'h00, 1'b1);     // R4 A into D
    exec({4'b1000, 2'd2, 2'd2}, 8'h00, 1'b1);     // R4 self copy
    exec({6'b100100, 2'd1}, 8'hA5, 1'b1);         // R5 load into B
    exec({6'b100110, 2'd2}, 8'h3C, 1'b1);         // R6 first complement code
    exec({6'b100111, 2'd2}, 8'h3C, 1'b1);         // R6 second complement code
    // R7 add with carry out dropped: A=C8, B=64 -> B=2C
    exec(8'h0C, 8'h00, 1'b1); exec(8'h48, 8'h00, 1'b1);
    exec(8'h16, 8'h00, 1'b1); exec(8'h54, 8'h00, 1'b1);
    exec({4'b1010, 2'd0, 2'd1}, 8'h00, 1'b1);
    // R7 multiply truncation: A=10, C=11 -> C=10
    exec(8'h01, 8'h00, 1'b1); exec(8'h40, 8'h00, 1'b1);
    exec(8'h21, 8'h00, 1'b1); exec(8'h61, 8'h00, 1'b1);
    exec({4'b1011, 2'd0, 2'd2}, 8'h00, 1'b1);
    exec({4'b1100, 2'd1, 2'd3}, 8'h00, 1'b1);     // R8 and
    exec({4'b1101, 2'd0, 2'd1}, 8'h00, 1'b1);     // R8 or
    exec({4'b1111, 2'd1, 2'd2}, 8'h00, 1'b1);     // R9 store B at [C]
    exec({4'b1111, 2'd3, 2'd0}, 8'h00, 1'b1);     // R9 store D at [A]
    for (int k = 0; k < 4; k++) exec({6'b100101, 2'(k)}, 8'hFF, 1'b1); // R10
    exec(8'hE0, 8'hFF, 1'b1); exec(8'hE7, 8'hFF, 1'b1); exec(8'hEF, 8'hFF, 1'b1);
    exec(8'hFF, 8'h77, 1'b0); exec(8'h00, 8'h77, 1'b0); exec(8'h91, 8'h77, 1'b0); // R11

    // Pseudo-random stream across all codes
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      exec(lfsr[7:0], lfsr[15:8] ^ 8'h5A, lfsr[3] | lfsr[9]);
    end

    // R1 reset in the middle of a run while a store is offered
    exec(8'hFF, 8'h00, 1'b0);
    @(negedge clk); #1;
    @(negedge clk);
    rst = 1'b1; instr = 8'hF4; instr_valid = 1'b1;
    #1;
    checks++;
    if (mem_we !== 1'b0 || instr_ready !== 1'b0) begin
      failures++;
      $display("FAIL R1 port in reset: got we=%b rdy=%b, expected we=0 rdy=0", mem_we, instr_ready);
    end
    @(negedge clk); #1 check_reset_state("R1 reset mid-run");
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    @(negedge clk); rst = 1'b0; instr_valid = 1'b0;
    exec(8'h3A, 8'h00, 1'b1);
    exec({4'b1111, 2'd3, 2'd3}, 8'h00, 1'b1);
    exec(8'h00, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule